// File: doc/BRIEF.md
# Overlay Window Register Target

This block is a device-side model of a non-volatile memory that hides a small command register bank behind its normal array space. A separate mode-register port switches the register bank in and out. After a configuration write that arms the port, a data write of one value shows the window and another value hides it. While the window is hidden, reads on the word-addressed bus return array contents one cycle later. While the window is shown, the same bus reads an identification tag and a program-buffer pointer, stores command, data, target-address and word-count registers, accepts words into a small program buffer, and starts the stored command when the execute register is written.

A started command makes the block busy. First it writes the affected array words, one per cycle. Then it waits a programmable number of cycles before the ready bit of the status register comes back. Commands act only on the internal array RAM and on a per-block lock bitmap. Single-word and buffered programs behave the same as their overwrite forms, because cell physics is not modelled. The host polls the status register to learn when a command has finished and whether it failed.

Top module: `owin_target`

## Requirements
- R1: After reset the window is hidden, every array word reads 0xFFFF, and the status register reads 0x0080 (ready bit 7 set, error bit 4 clear) once the window is shown.
- R2: A mode data write (`mr_is_data`=1) of 0x0001 shows the window and 0x0002 hides it. Either one acts only if the mode-port write just before it was a configuration write whose bits [7:0] are 0x18 and whose bit 15 is set. Any data write clears that arming, and other configuration values clear it too.
- R3: While shown, word offsets 0, 1, 2 and 3 read 0x0050, 0x0046, 0x004F and 0x0057. Word offset 0x08 reads the program-buffer base offset (0x0080 by default).
- R4: While shown, the command register (word 0x40), data (0x42), address low/high (0x44/0x45) and count low/high (0x48/0x49) read back what was written to them. An unmapped offset reads 0.
- R5: While hidden, a read at address A returns array word A in the next cycle. Bus writes while hidden change neither the array nor any register.
- R6: Writing 0x0001 to word 0x60 while idle starts the stored command, and the status register at word 0x66 reads ready=0 from the next cycle on. Ready returns after N+BUSY_CYCLES clock edges, where N is the number of array words the command writes. Any other value written to 0x60 starts nothing.
- R7: Commands 0x0041 and 0x0042 write the data register to array word {addr_hi,addr_lo} mod 2^AW.
- R8: Commands 0x00E9 and 0x00EA copy min({count_hi,count_lo}, PBUF_DEPTH) program-buffer words to consecutive array addresses from the target. The buffer is filled at word offsets PBUF_BASE to PBUF_BASE+PBUF_DEPTH-1.
- R9: Command 0x0020 sets every word of the BLK_WORDS-aligned block that holds the target to 0xFFFF and leaves other blocks unchanged.
- R10: Command 0x0061 locks the target's block and 0x0062 unlocks it. A program or erase whose target block is locked changes no array word and completes with status 0x0090.
- R11: Any other command code completes with the ready bit and the error bit set (0x0090).
- R12: While a command is busy, writes to the command, data, address, count, execute and program-buffer registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_we | input | 1 | Mode-register write strobe |
| mr_is_data | input | 1 | 0: configuration write, 1: data write |
| mr_wdata | input | 16 | Mode-register write value |
| bus_en | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1: write, 0: read |
| bus_addr | input | AW (8) | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |

## Verification
The mode port is exercised with unarmed data writes, armed writes and writes whose arming was cancelled. These patterns separate a correct arming rule from one that trusts any data write. Each command class runs against unlocked and locked blocks, and buffered counts are taken below the buffer depth and above it through the high count half. This shows whether the limit applies, whether the lock is honoured, and whether erase stays inside its block. The status register is read on every cycle of a busy period, so a ready bit that returns one edge early or late is caught. Register and execute writes issued while busy confirm that the stored command is frozen.

// File: rtl/owin_pkg.sv
package owin_pkg;
  localparam int DW = 16;

  // window word offsets (host-visible layout)
  localparam int OFS_ID0   = 'h00;
  localparam int OFS_ID1   = 'h01;
  localparam int OFS_ID2   = 'h02;
  localparam int OFS_ID3   = 'h03;
  localparam int OFS_PBOFS = 'h08;
  localparam int OFS_CMD   = 'h40;
  localparam int OFS_DATA  = 'h42;
  localparam int OFS_ADRL  = 'h44;
  localparam int OFS_ADRH  = 'h45;
  localparam int OFS_CNTL  = 'h48;
  localparam int OFS_CNTH  = 'h49;
  localparam int OFS_EXEC  = 'h60;
  localparam int OFS_STAT  = 'h66;

  localparam int STAT_RDY = 7;
  localparam int STAT_ERR = 4;

  localparam logic [DW-1:0] OP_LOCK    = 16'h0061;
  localparam logic [DW-1:0] OP_UNLOCK  = 16'h0062;
  localparam logic [DW-1:0] OP_SW_PROG = 16'h0041;
  localparam logic [DW-1:0] OP_SW_OVWR = 16'h0042;
  localparam logic [DW-1:0] OP_BF_PROG = 16'h00E9;
  localparam logic [DW-1:0] OP_BF_OVWR = 16'h00EA;
  localparam logic [DW-1:0] OP_ERASE   = 16'h0020;

  typedef enum logic [1:0] {ST_IDLE, ST_APPLY, ST_WAIT} eng_state_t;
  typedef enum logic [1:0] {SRC_DATA, SRC_PBUF, SRC_ONES} wsrc_t;
endpackage

// File: rtl/owin_modereg.sv
module owin_modereg
  import owin_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          mr_we,
  input  logic          mr_is_data,
  input  logic [DW-1:0] mr_wdata,
  output logic          win_en
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      win_en  <= 1'b0;
    end else if (mr_we) begin
      if (!mr_is_data) begin
        armed_q <= (mr_wdata[7:0] == 8'h18) && mr_wdata[DW-1];
      end else begin
        armed_q <= 1'b0;
        if (armed_q) begin
          if (mr_wdata == 16'h0001)      win_en <= 1'b1;
          else if (mr_wdata == 16'h0002) win_en <= 1'b0;
        end
      end
    end
  end

  // R2: the window only appears after an armed data write
  a_r2_show_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $rose(win_en) |-> ($past(armed_q) && $past(mr_we) && $past(mr_is_data)));
  a_r2_hide_needs_arm: assert property (@(posedge clk) disable iff (rst)
    $fell(win_en) |-> ($past(armed_q) && $past(mr_we) && $past(mr_is_data)));
endmodule

// File: rtl/owin_array.sv
module owin_array #(
  parameter int AW = 8,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  // erased state at configuration
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/owin_engine.sv
module owin_engine
  import owin_pkg::*;
#(
  parameter int AW          = 8,
  parameter int PBUF_DEPTH  = 16,
  parameter int BLK_WORDS   = 32,
  parameter int BUSY_CYCLES = 4,
  parameter int PBUF_BASE   = 'h80,
  localparam int BLK_BITS = $clog2(BLK_WORDS),
  localparam int NBLK     = 1 << (AW - BLK_BITS),
  localparam int PB_BITS  = $clog2(PBUF_DEPTH),
  localparam int NMAX     = (BLK_WORDS > PBUF_DEPTH) ? BLK_WORDS : PBUF_DEPTH,
  localparam int N_W      = $clog2(NMAX + 1),
  localparam int WT_W     = $clog2(BUSY_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win_en,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] win_q,
  output logic          arr_we,
  output logic [AW-1:0] arr_waddr,
  output logic [DW-1:0] arr_wdata
);
  logic [DW-1:0] cmd_q, data_q, adrl_q, adrh_q, cntl_q, cnth_q;
  logic [DW-1:0] pbuf [PBUF_DEPTH];
  logic [NBLK-1:0] lock_q;
  eng_state_t      state_q;
  wsrc_t           src_q, src_new;
  logic [N_W-1:0]  idx_q, n_q, n_new, buf_n;
  logic [AW-1:0]   base_q, base_new, tgt, pb_off;
  logic [WT_W-1:0] wcnt_q;
  logic            ready_q, err_q, perr_q, err_new, lk_set, lk_clr;
  logic            busy, reg_wr, exec, pb_hit, tlock;
  logic [AW-BLK_BITS-1:0] tblk;
  logic [2*DW-1:0] adr32, cnt32;
  logic [DW-1:0]   stat;

  assign busy   = (state_q != ST_IDLE);
  assign reg_wr = bus_en && bus_we && win_en && !busy;
  assign exec   = reg_wr && (bus_addr == AW'(OFS_EXEC)) && (bus_wdata == 16'h0001);
  assign adr32  = {adrh_q, adrl_q};
  assign cnt32  = {cnth_q, cntl_q};
  assign tgt    = adr32[AW-1:0];
  assign tblk   = tgt[AW-1:BLK_BITS];
  assign tlock  = lock_q[tblk];
  assign buf_n  = (cnt32 > 32'(PBUF_DEPTH)) ? N_W'(PBUF_DEPTH) : N_W'(cnt32);
  assign pb_off = bus_addr - AW'(PBUF_BASE);
  assign pb_hit = (bus_addr >= AW'(PBUF_BASE)) && (pb_off < AW'(PBUF_DEPTH));

  // command decode from the stored registers
  always_comb begin
    n_new = '0; err_new = 1'b0; src_new = SRC_DATA; base_new = tgt;
    lk_set = 1'b0; lk_clr = 1'b0;
    case (cmd_q)
      OP_LOCK:   lk_set = 1'b1;
      OP_UNLOCK: lk_clr = 1'b1;
      OP_SW_PROG, OP_SW_OVWR: begin
        if (tlock) err_new = 1'b1;
        else       n_new = N_W'(1);
      end
      OP_BF_PROG, OP_BF_OVWR: begin
        if (tlock) err_new = 1'b1;
        else begin n_new = buf_n; src_new = SRC_PBUF; end
      end
      OP_ERASE: begin
        if (tlock) err_new = 1'b1;
        else begin
          n_new = N_W'(BLK_WORDS); src_new = SRC_ONES;
          base_new = tgt & ~AW'(BLK_WORDS - 1);
        end
      end
      default: err_new = 1'b1;
    endcase
  end

  // program buffer: small distributed RAM
  always_ff @(posedge clk) begin
    if (reg_wr && pb_hit) pbuf[pb_off[PB_BITS-1:0]] <= bus_wdata;
  end

  // host-visible registers and the command sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0; data_q <= '0; adrl_q <= '0; adrh_q <= '0; cntl_q <= '0; cnth_q <= '0;
      lock_q <= '0; state_q <= ST_IDLE; src_q <= SRC_DATA;
      idx_q <= '0; n_q <= '0; base_q <= '0; wcnt_q <= '0;
      ready_q <= 1'b1; err_q <= 1'b0; perr_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (bus_addr)
          AW'(OFS_CMD):  cmd_q  <= bus_wdata;
          AW'(OFS_DATA): data_q <= bus_wdata;
          AW'(OFS_ADRL): adrl_q <= bus_wdata;
          AW'(OFS_ADRH): adrh_q <= bus_wdata;
          AW'(OFS_CNTL): cntl_q <= bus_wdata;
          AW'(OFS_CNTH): cnth_q <= bus_wdata;
          default: ;
        endcase
      end
      case (state_q)
        ST_IDLE: if (exec) begin
          if (lk_set) lock_q[tblk] <= 1'b1;
          if (lk_clr) lock_q[tblk] <= 1'b0;
          ready_q <= 1'b0; err_q <= 1'b0; perr_q <= err_new;
          n_q <= n_new; base_q <= base_new; src_q <= src_new;
          idx_q <= '0; wcnt_q <= '0;
          state_q <= (n_new != '0) ? ST_APPLY : ST_WAIT;
        end
        ST_APPLY: begin
          if (idx_q == n_q - 1'b1) state_q <= ST_WAIT;
          else                     idx_q <= idx_q + 1'b1;
        end
        ST_WAIT: begin
          if (wcnt_q == WT_W'(BUSY_CYCLES - 1)) begin
            state_q <= ST_IDLE; ready_q <= 1'b1; err_q <= perr_q;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign arr_we    = (state_q == ST_APPLY);
  assign arr_waddr = base_q + AW'(idx_q);
  always_comb begin
    case (src_q)
      SRC_PBUF: arr_wdata = pbuf[idx_q[PB_BITS-1:0]];
      SRC_ONES: arr_wdata = '1;
      default:  arr_wdata = data_q;
    endcase
  end

  always_comb begin
    stat = '0;
    stat[STAT_RDY] = ready_q;
    stat[STAT_ERR] = err_q;
  end

  // registered window read
  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else if (bus_en && !bus_we && win_en) begin
      case (bus_addr)
        AW'(OFS_ID0):   win_q <= 16'h0050;
        AW'(OFS_ID1):   win_q <= 16'h0046;
        AW'(OFS_ID2):   win_q <= 16'h004F;
        AW'(OFS_ID3):   win_q <= 16'h0057;
        AW'(OFS_PBOFS): win_q <= DW'(PBUF_BASE);
        AW'(OFS_CMD):   win_q <= cmd_q;
        AW'(OFS_DATA):  win_q <= data_q;
        AW'(OFS_ADRL):  win_q <= adrl_q;
        AW'(OFS_ADRH):  win_q <= adrh_q;
        AW'(OFS_CNTL):  win_q <= cntl_q;
        AW'(OFS_CNTH):  win_q <= cnth_q;
        AW'(OFS_STAT):  win_q <= stat;
        default:        win_q <= '0;
      endcase
    end
  end

  // R6: execute drops ready; ready stays low while busy
  a_r6_exec_drops_ready: assert property (@(posedge clk) disable iff (rst)
    exec |=> !ready_q);
  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ready_q);
  // R12: stored command frozen while busy
  a_r12_cmd_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cmd_q) && $stable(data_q) && $stable(adrl_q)));
  // R10: no array write into a locked target block
  a_r10_no_locked_write: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !lock_q[base_q[AW-1:BLK_BITS]]);
  // R8: write index stays inside the word count
  a_r8_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_APPLY) |-> (idx_q < n_q));
endmodule

// File: rtl/owin_target.sv
module owin_target
  import owin_pkg::*;
#(
  parameter int AW          = 8,
  parameter int PBUF_DEPTH  = 16,
  parameter int BLK_WORDS   = 32,
  parameter int BUSY_CYCLES = 4,
  parameter int PBUF_BASE   = 'h80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mr_we,
  input  logic          mr_is_data,
  input  logic [15:0]   mr_wdata,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata
);
  logic          win_en, sel_win_q, arr_we;
  logic [AW-1:0] arr_waddr;
  logic [DW-1:0] arr_wdata, arr_q, win_q;

  owin_modereg u_mode (
    .clk, .rst, .mr_we, .mr_is_data, .mr_wdata, .win_en
  );

  owin_engine #(
    .AW(AW), .PBUF_DEPTH(PBUF_DEPTH), .BLK_WORDS(BLK_WORDS),
    .BUSY_CYCLES(BUSY_CYCLES), .PBUF_BASE(PBUF_BASE)
  ) u_eng (
    .clk, .rst, .win_en, .bus_en, .bus_we, .bus_addr, .bus_wdata,
    .win_q, .arr_we, .arr_waddr, .arr_wdata
  );

  owin_array #(.AW(AW), .DW(DW)) u_arr (
    .clk, .rst, .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .re(bus_en && !bus_we && !win_en), .raddr(bus_addr), .q(arr_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                    sel_win_q <= 1'b0;
    else if (bus_en && !bus_we) sel_win_q <= win_en;
  end

  assign bus_rdata = sel_win_q ? win_q : arr_q;
endmodule

// File: tb/owin_target_tb_top.sv
module owin_target_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int AW = 8, PBD = 16, BLK = 32, BUSY = 4, PBB = 'h80;

  logic clk = 1'b0, rst = 1'b1;
  logic mr_we = 1'b0, mr_is_data = 1'b0;
  logic [15:0] mr_wdata = '0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;

  always #2.5 clk = ~clk;

  owin_target #(.AW(AW), .PBUF_DEPTH(PBD), .BLK_WORDS(BLK),
                .BUSY_CYCLES(BUSY), .PBUF_BASE(PBB)) dut_i (
    .clk, .rst, .mr_we, .mr_is_data, .mr_wdata,
    .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata);

  int vectors = 0, miscompares = 0, cycles = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_arr [256];
  logic [15:0] m_pb [PBD];
  bit m_lk [256/BLK];
  logic [15:0] m_cmd, m_dat, m_alo, m_ahi, m_clo, m_chi, m_rd;
  bit m_arm, m_en, m_rdy, m_err, m_perr, busy_now;
  int m_busy;
  int q_a[$], q_d[$];

  initial for (int i = 0; i < 256; i++) m_arr[i] = 16'hFFFF;

  function automatic logic [15:0] win_read(int a);
    case (a)
      0: return 16'h0050;  1: return 16'h0046;
      2: return 16'h004F;  3: return 16'h0057;
      8: return 16'(PBB);
      'h40: return m_cmd; 'h42: return m_dat;
      'h44: return m_alo; 'h45: return m_ahi;
      'h48: return m_clo; 'h49: return m_chi;
      'h66: return {8'h00, m_rdy, 2'b00, m_err, 4'b0000};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic void mdl_exec();
    int t, blk; bit e; longint cnt, nw;
    t = int'({m_ahi, m_alo}) & 255;
    blk = t / BLK;
    e = 0;
    case (m_cmd)
      16'h0061: m_lk[blk] = 1;
      16'h0062: m_lk[blk] = 0;
      16'h0041, 16'h0042: if (m_lk[blk]) e = 1; else begin q_a.push_back(t); q_d.push_back(m_dat); end
      16'h00E9, 16'h00EA: if (m_lk[blk]) e = 1; else begin
        cnt = longint'(m_chi) * 65536 + longint'(m_clo);
        nw = (cnt > PBD) ? PBD : cnt;
        for (int i = 0; i < nw; i++) begin q_a.push_back((t + i) & 255); q_d.push_back(m_pb[i]); end
      end
      16'h0020: if (m_lk[blk]) e = 1; else
        for (int i = 0; i < BLK; i++) begin q_a.push_back(blk * BLK + i); q_d.push_back('hFFFF); end
      default: e = 1;
    endcase
    m_perr = e; m_rdy = 0; m_err = 0;
    m_busy = q_a.size() + BUSY;
  endfunction

  function automatic void mdl_write(int a, logic [15:0] d);
    case (a)
      'h40: m_cmd = d; 'h42: m_dat = d;
      'h44: m_alo = d; 'h45: m_ahi = d;
      'h48: m_clo = d; 'h49: m_chi = d;
      'h60: if (d == 16'h0001) mdl_exec();
      default: if (a >= PBB && a < PBB + PBD) m_pb[a - PBB] = d;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_arm = 0; m_en = 0; m_rdy = 1; m_err = 0; m_perr = 0; m_busy = 0;
      m_cmd = 0; m_dat = 0; m_alo = 0; m_ahi = 0; m_clo = 0; m_chi = 0; m_rd = 0;
      for (int i = 0; i < 256/BLK; i++) m_lk[i] = 0;
      q_a.delete(); q_d.delete();
    end else begin
      busy_now = (m_busy > 0);
      if (bus_en && !bus_we) m_rd = m_en ? win_read(int'(bus_addr)) : m_arr[bus_addr];
      if (m_busy > 0) begin
        if (q_a.size() > 0) m_arr[q_a.pop_front()] = 16'(q_d.pop_front());
        m_busy--;
        if (m_busy == 0) begin m_rdy = 1; m_err = m_perr; end
      end
      if (bus_en && bus_we && m_en && !busy_now) mdl_write(int'(bus_addr), bus_wdata);
      if (mr_we) begin
        if (!mr_is_data) m_arm = (mr_wdata[7:0] == 8'h18) && mr_wdata[15];
        else begin
          if (m_arm) begin
            if (mr_wdata == 16'h0001) m_en = 1;
            else if (mr_wdata == 16'h0002) m_en = 0;
          end
          m_arm = 0;
        end
      end
    end
  end

  // every-cycle comparison and watchdog
  always @(negedge clk) begin
    cycles++;
    vectors++;
    if (bus_rdata !== m_rd) begin
      miscompares++;
      $display("FAIL %s cycle %0d: bus_rdata got %h expected %h", cur_req, cycles, bus_rdata, m_rd);
    end
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL %s watchdog: got %0d cycles expected fewer than 100000", cur_req, cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drv(input logic en, input logic we, input int a, input int d);
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = AW'(a); bus_wdata = 16'(d); mr_we = 1'b0;
  endtask
  task automatic wr(input int a, input int d); drv(1'b1, 1'b1, a, d); endtask
  task automatic rd(input int a); drv(1'b1, 1'b0, a, 0); endtask
  task automatic idle(input int n); repeat (n) drv(1'b0, 1'b0, 0, 0); endtask
  task automatic mode(input logic is_data, input int d);
    @(negedge clk);
    bus_en = 1'b0; mr_we = 1'b1; mr_is_data = is_data; mr_wdata = 16'(d);
  endtask
  task automatic win_on();  mode(1'b0, 'h8018); mode(1'b1, 1); idle(1); endtask
  task automatic win_off(); mode(1'b0, 'h8018); mode(1'b1, 2); idle(1); endtask
  task automatic chk(input int a, input logic [15:0] exp, input string req);
    cur_req = req;
    rd(a); idle(1);
    #1;
    vectors++;
    if (bus_rdata !== exp) begin
      miscompares++;
      $display("FAIL %s read @%h: got %h expected %h", req, a, bus_rdata, exp);
    end
  endtask
  task automatic run(input int cmd, input int alo);
    wr('h44, alo); wr('h45, 0); wr('h40, cmd); wr('h60, 1); idle(45);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R1: reset state
    chk('h00, 16'hFFFF, "R1");
    chk('h7F, 16'hFFFF, "R1");

    // R2: arming rules
    mode(1'b1, 1); idle(1);
    chk('h00, 16'hFFFF, "R2");
    mode(1'b0, 'h0018); mode(1'b1, 1); idle(1);
    chk('h00, 16'hFFFF, "R2");
    win_on();
    chk('h00, 16'h0050, "R2");
    chk('h66, 16'h0080, "R1");
    mode(1'b0, 'h8018); mode(1'b0, 'h0000); mode(1'b1, 2); idle(1);
    chk('h00, 16'h0050, "R2");

    // R3: identification and buffer pointer
    chk('h01, 16'h0046, "R3");
    chk('h02, 16'h004F, "R3");
    chk('h03, 16'h0057, "R3");
    chk('h08, 16'h0080, "R3");

    // R4: register readback
    wr('h40, 'h0077); wr('h42, 'hBEEF); wr('h44, 'h0012); wr('h45, 'h0003);
    wr('h48, 'h0005); wr('h49, 'h0000); idle(1);
    chk('h40, 16'h0077, "R4");
    chk('h42, 16'hBEEF, "R4");
    chk('h44, 16'h0012, "R4");
    chk('h45, 16'h0003, "R4");
    chk('h48, 16'h0005, "R4");
    chk('h30, 16'h0000, "R4");

    // R7 and R6: single-word write, busy window observed every cycle
    cur_req = "R6";
    wr('h42, 'h1234); wr('h44, 5); wr('h45, 0); wr('h40, 'h0042); wr('h60, 1);
    chk('h66, 16'h0000, "R6");
    for (int i = 0; i < 12; i++) rd('h66);
    idle(2);
    chk('h66, 16'h0080, "R6");
    wr('h60, 2); idle(1);
    chk('h66, 16'h0080, "R6");

    // R12: writes ignored while busy
    wr('h42, 'hABCD); wr('h44, 6); wr('h40, 'h0041); wr('h60, 1);
    wr('h40, 'h0099); wr('h42, 'h5555); wr('h60, 1); wr('h87, 'h7777);
    idle(12);
    chk('h40, 16'h0041, "R12");
    chk('h42, 16'hABCD, "R12");

    // R8: buffered writes, short count and clamped count
    cur_req = "R8";
    for (int i = 0; i < PBD; i++) wr(PBB + i, 'h1000 + i);
    wr('h48, 3); wr('h49, 0);
    run('h00EA, 'h20);
    wr('h48, 0); wr('h49, 1);
    run('h00E9, 'h40);

    // R5: hidden window reads the array, writes ignored
    win_off();
    chk('h05, 16'h1234, "R7");
    chk('h06, 16'hABCD, "R7");
    chk('h20, 16'h1000, "R8");
    chk('h22, 16'h1002, "R8");
    chk('h23, 16'hFFFF, "R8");
    chk('h40, 16'h1000, "R8");
    chk('h4F, 16'h100F, "R8");
    chk('h50, 16'hFFFF, "R8");
    wr('h05, 0); wr('h40, 'h0000); idle(1);
    chk('h05, 16'h1234, "R5");
    win_on();
    chk('h40, 16'h00E9, "R5");

    // R10: lock blocks program and erase
    wr('h42, 'h0F0F);
    run('h0061, 'h21);
    run('h0041, 'h21);
    chk('h66, 16'h0090, "R10");
    run('h0020, 'h21);
    chk('h66, 16'h0090, "R10");
    win_off();
    chk('h21, 16'h1001, "R10");
    win_on();
    run('h0062, 'h21);
    chk('h66, 16'h0080, "R10");

    // R9: erase one block only
    run('h0020, 'h3A);
    chk('h66, 16'h0080, "R9");
    win_off();
    chk('h20, 16'hFFFF, "R9");
    chk('h21, 16'hFFFF, "R9");
    chk('h40, 16'h1000, "R9");
    chk('h06, 16'hABCD, "R9");
    win_on();

    // R11: unknown command
    cur_req = "R11";
    wr('h40, 'h0077); wr('h60, 1);
    for (int i = 0; i < 8; i++) rd('h66);
    idle(1);
    chk('h66, 16'h0090, "R11");

    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule